// File: doc/BRIEF.md
# Pipelined Karatsuba Wide Multiplier

This block multiplies two unsigned operands of `W` bits (64 by default) and returns the exact `2W`-bit product. Each operand is split into an upper and a lower half. Only three half-width products are formed: upper times upper, lower times lower, and the product of the two half-sums. The middle term of the product is rebuilt by subtracting the outer two products from the half-sum product, and the three parts are then added together at full width. The parameter `LEVELS` selects whether each half-width product is a plain multiply (`LEVELS=1`) or is itself split the same way once more (`LEVELS=2`).

The pipeline takes a new operand pair on every clock and returns one product per clock after a fixed latency of `1 + 4*LEVELS` cycles: 5 cycles for one level and 9 for two. Both input and output use a valid/ready stream. Back-pressure rule: the whole pipeline advances on a cycle unless the output holds a valid product and the consumer is not ready. In a stalled cycle every stage holds its contents, `in_ready` is low and no input is taken. Bubbles in the input stream travel down the pipeline as empty slots and are not squeezed out.

Top module: `wide_kara_mul`

## Requirements
- R1: For any pair of `W`-bit unsigned operands, `out_prod` equals their exact `2W`-bit product with no wrap. This includes the all-ones by all-ones pair, whose product is 2^(2W) - 2^(W+1) + 1.
- R2: When the output is never stalled, a pair accepted at a rising edge appears with `out_valid` high exactly `1 + 4*LEVELS` rising edges later. `out_valid` stays low in the cycles before that.
- R3: Pairs accepted on consecutive clocks produce products on consecutive clocks, in acceptance order, one per clock.
- R4: `out_valid` is high only in cycles that carry the product of an accepted pair. Input bubbles appear as low-`out_valid` cycles, and every accepted pair is delivered exactly once.
- R5: A synchronous active-high `rst` clears every valid flag. `out_valid` is low in each cycle after a reset edge until new accepted pairs reach the output. This holds even when reset arrives with products in flight.
- R6: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. In such a cycle, `out_valid` and `out_prod` keep their values into the next cycle, and `in_valid` has no effect.
- R7: With `LEVELS=2` the products are the same as in R1, at a latency of 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is offered |
| in_ready | output | 1 | Block takes the offered pair at this edge |
| in_a | input | W | First unsigned operand |
| in_b | input | W | Second unsigned operand |
| out_valid | output | 1 | `out_prod` carries a product |
| out_ready | input | 1 | Consumer takes the product at this edge |
| out_prod | output | 2W | Unsigned product |

## Verification
A wrong internal value shows in different ways depending on where it sits. An error in the pre-add, in a sub-product or in the recombine corrupts `out_prod` exactly `1 + 4*LEVELS` cycles after the bad pair is accepted. Carries out of the half-sums or out of the cross term only show up on operands near all-ones, so every such operand pair is swept. A misaligned delay register mixes terms from neighbouring pairs, which shows only in back-to-back traffic. A wrong valid or stall path shows at once as a product appearing in the wrong cycle, a product repeated or lost, or a value that changes while the output is stalled.

// File: rtl/kmul_pkg.sv
`timescale 1ns/1ps
package kmul_pkg;
  // Recursion depths the core supports.
  localparam int KMUL_MAX_LEVELS = 2;

  // Cycles from an accepted pair to its product: a leaf multiply is one
  // register stage, and every decomposition level adds a pre-add stage plus
  // three recombine stages around its sub-multipliers.
  function automatic int kmul_latency(input int levels);
    return 1 + 4 * levels;
  endfunction
endpackage

// File: rtl/kmul_leaf.sv
`timescale 1ns/1ps
// Plain registered multiply used at the bottom of the decomposition.
module kmul_leaf #(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           en,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int OW = 2 * N;

  always_ff @(posedge clk) begin
    if (en) p <= OW'(a) * OW'(b);
  end
endmodule

// File: rtl/kmul_kara.sv
`timescale 1ns/1ps
// One decomposition level: split, pre-add, three sub-products, recombine.
// DEPTH > 1 builds the sub-products from this module one level shallower.
module kmul_kara #(
  parameter int N     = 64,
  parameter int DEPTH = 1
) (
  input  logic           clk,
  input  logic           en,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int HW = N / 2;        // upper half width
  localparam int LW = N - HW;       // lower half width (>= HW)
  localparam int SW = LW + 1;       // half-sum width
  localparam int PW = 2 * SW;       // half-sum product / cross term width
  localparam int OW = 2 * N;

  // Stage 1: halves and half-sums.
  logic [HW-1:0] a_hi_q, b_hi_q;
  logic [LW-1:0] a_lo_q, b_lo_q;
  logic [SW-1:0] a_sum_q, b_sum_q;

  always_ff @(posedge clk) begin
    if (en) begin
      a_hi_q  <= a[N-1:LW];
      b_hi_q  <= b[N-1:LW];
      a_lo_q  <= a[LW-1:0];
      b_lo_q  <= b[LW-1:0];
      a_sum_q <= SW'(a[N-1:LW]) + SW'(a[LW-1:0]);
      b_sum_q <= SW'(b[N-1:LW]) + SW'(b[LW-1:0]);
    end
  end

  // Sub-products, all with the same latency.
  logic [2*HW-1:0] p_hh;
  logic [2*LW-1:0] p_ll;
  logic [PW-1:0]   p_ss;

  generate
    if (DEPTH <= 1) begin : g_leaf
      kmul_leaf #(.N(HW)) u_hh (.clk(clk), .en(en), .a(a_hi_q),  .b(b_hi_q),  .p(p_hh));
      kmul_leaf #(.N(LW)) u_ll (.clk(clk), .en(en), .a(a_lo_q),  .b(b_lo_q),  .p(p_ll));
      kmul_leaf #(.N(SW)) u_ss (.clk(clk), .en(en), .a(a_sum_q), .b(b_sum_q), .p(p_ss));
    end else begin : g_nest
      kmul_kara #(.N(HW), .DEPTH(DEPTH-1)) u_hh (.clk(clk), .en(en), .a(a_hi_q),  .b(b_hi_q),  .p(p_hh));
      kmul_kara #(.N(LW), .DEPTH(DEPTH-1)) u_ll (.clk(clk), .en(en), .a(a_lo_q),  .b(b_lo_q),  .p(p_ll));
      kmul_kara #(.N(SW), .DEPTH(DEPTH-1)) u_ss (.clk(clk), .en(en), .a(a_sum_q), .b(b_sum_q), .p(p_ss));
    end
  endgenerate

  // Stage A: sum of the outer products; outer products and half-sum product
  // captured side by side so they stay aligned.
  logic [2*HW-1:0] hh_a;
  logic [2*LW-1:0] ll_a;
  logic [PW-1:0]   ss_a, outer_a;

  always_ff @(posedge clk) begin
    if (en) begin
      hh_a    <= p_hh;
      ll_a    <= p_ll;
      ss_a    <= p_ss;
      outer_a <= PW'(p_hh) + PW'(p_ll);
    end
  end

  // Stage B: full-width cross term, never negative.
  logic [2*HW-1:0] hh_b;
  logic [2*LW-1:0] ll_b;
  logic [PW-1:0]   cross_b;

  always_ff @(posedge clk) begin
    if (en) begin
      hh_b    <= hh_a;
      ll_b    <= ll_a;
      cross_b <= ss_a - outer_a;
    end
  end

  // Stage C: outer products side by side, cross term added at the split.
  always_ff @(posedge clk) begin
    if (en) p <= {hh_b, ll_b} + (OW'(cross_b) << LW);
  end
endmodule

// File: rtl/kmul_valid_pipe.sv
`timescale 1ns/1ps
// Valid flags that travel beside the data stages.
module kmul_valid_pipe #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic vin,
  output logic vout
);
  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst)     flags <= '0;
    else if (en) flags <= {flags[DEPTH-2:0], vin};
  end

  assign vout = flags[DEPTH-1];
endmodule

// File: rtl/wide_kara_mul.sv
`timescale 1ns/1ps
module wide_kara_mul
  import kmul_pkg::*;
#(
  parameter int W      = 64,
  parameter int LEVELS = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_prod
);
  localparam int LAT = kmul_latency(LEVELS);

  // Whole pipeline advances unless a held product is refused.
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  kmul_kara #(.N(W), .DEPTH(LEVELS)) u_core (
    .clk(clk), .en(advance), .a(in_a), .b(in_b), .p(out_prod)
  );

  kmul_valid_pipe #(.DEPTH(LAT)) u_vpipe (
    .clk(clk), .rst(rst), .en(advance), .vin(in_valid), .vout(out_valid)
  );
endmodule

// File: rtl/wide_kara_mul_chk.sv
`timescale 1ns/1ps
module wide_kara_mul_chk #(
  parameter int W   = 64,
  parameter int LAT = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_prod
);
  localparam int CW = $clog2(LAT + 1) + 2;
  localparam logic [2*W-1:0] ONES  = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [2*W-1:0] MAXSQ = ONES * ONES;

  logic          take_in, give_out, rst_seen;
  logic [CW-1:0] in_flight;

  assign take_in  = in_valid && in_ready;
  assign give_out = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) in_flight <= '0;
    else     in_flight <= in_flight + CW'(take_in) - CW'(give_out);
  end

  // R5: a reset edge leaves no valid product behind.
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      a_reset_clear_r5: assert (!out_valid) else $error("valid survived reset");
    end
  end

  // R6: a refused product holds.
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R4: never more pairs in flight than pipeline slots.
  p_occupancy_r4: assert property (@(posedge clk) disable iff (rst)
    in_flight <= CW'(LAT));

  // R4: no product shown when nothing was accepted.
  p_no_phantom_r4: assert property (@(posedge clk) disable iff (rst)
    (in_flight == '0) |-> !out_valid);

  // R1: a product never exceeds the all-ones square.
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_prod <= MAXSQ));
endmodule

bind wide_kara_mul wide_kara_mul_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
);

// File: tb/test_wide_kara_mul.sv
`timescale 1ns/1ps
module test_wide_kara_mul;
  localparam int BW = 64, BLAT = 5;   // default configuration
  localparam int SWD = 8, SLAT = 9;   // small two-level configuration

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;               // 125 MHz

  logic            a_v = 1'b0, a_r = 1'b1, a_ir, a_ov;
  logic [BW-1:0]   a_a = '0, a_b = '0;
  logic [2*BW-1:0] a_p;
  logic            s_v = 1'b0, s_r = 1'b1, s_ir, s_ov;
  logic [SWD-1:0]  s_a = '0, s_b = '0;
  logic [2*SWD-1:0] s_p;

  wide_kara_mul #(.W(BW), .LEVELS(1)) i_wide_kara_mul (
    .clk(clk), .rst(rst), .in_valid(a_v), .in_ready(a_ir), .in_a(a_a), .in_b(a_b),
    .out_valid(a_ov), .out_ready(a_r), .out_prod(a_p));

  wide_kara_mul #(.W(SWD), .LEVELS(2)) i_wide_kara_mul_x8 (
    .clk(clk), .rst(rst), .in_valid(s_v), .in_ready(s_ir), .in_a(s_a), .in_b(s_b),
    .out_valid(s_ov), .out_ready(s_r), .out_prod(s_p));

  int nchk = 0, nfail = 0, cyc = 0;
  string cur_req = "R1";
  bit lat_mode = 1'b0;
  logic [127:0] qb[$];
  int qbt[$];
  logic [15:0] qs[$];
  int qst[$];
  bit prev_stall = 1'b0;
  logic [127:0] prev_p = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Inputs are set just after a falling edge; this settles, scores the
  // coming rising edge, then moves to the next falling edge.
  task automatic step();
    #1;
    if (!rst) begin
      if (prev_stall) begin
        chk(a_ov, "R6", 128'(a_ov), 128'd1);
        chk(a_p == prev_p, "R6", a_p, prev_p);
      end
      if (a_ov && !a_r) chk(!a_ir, "R6", 128'(a_ir), 128'd0);
      if (a_v && a_ir) begin
        qb.push_back(128'(a_a) * 128'(a_b));
        qbt.push_back(cyc);
      end
      if (s_v && s_ir) begin
        qs.push_back(16'(s_a) * 16'(s_b));
        qst.push_back(cyc);
      end
      if (a_ov && a_r) begin
        if (qb.size() == 0) chk(1'b0, "R4", a_p, 128'd0);
        else begin
          logic [127:0] e = qb.pop_front();
          int t = qbt.pop_front();
          chk(a_p == e, cur_req, a_p, e);
          if (lat_mode) chk(cyc - t == BLAT, "R3", 128'(cyc - t), 128'(BLAT));
        end
      end
      if (s_ov && s_r) begin
        if (qs.size() == 0) chk(1'b0, "R4", 128'(s_p), 128'd0);
        else begin
          logic [15:0] e = qs.pop_front();
          int t = qst.pop_front();
          chk(s_p == e, "R7", 128'(s_p), 128'(e));
          chk(cyc - t == SLAT, "R7", 128'(cyc - t), 128'(SLAT));
        end
      end
      prev_stall = a_ov && !a_r;
      prev_p = a_p;
    end else prev_stall = 1'b0;
    @(negedge clk);
    cyc++;
  endtask

  task automatic drain();
    a_v = 1'b0; s_v = 1'b0; a_r = 1'b1;
    for (int k = 0; k < 14; k++) step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] corners [8];
    corners[0] = 64'd0;                 corners[1] = 64'd1;
    corners[2] = '1;                    corners[3] = 64'h8000_0000_0000_0000;
    corners[4] = 64'h0000_0001_0000_0000; corners[5] = 64'h0000_0000_FFFF_FFFF;
    corners[6] = 64'hFFFF_FFFF_0000_0000; corners[7] = 64'hFFFF_FFFF_FFFF_FFFE;

    @(negedge clk);
    // R5: reset state.
    for (int k = 0; k < 3; k++) begin
      #1; chk(!a_ov && !s_ov, "R5", 128'(a_ov), 128'd0);
      @(negedge clk); cyc++;
    end
    rst = 1'b0;
    for (int k = 0; k < 2; k++) begin
      #1; chk(!a_ov && !s_ov, "R5", 128'(s_ov), 128'd0);
      @(negedge clk); cyc++;
    end

    // R2: single pair latency on both configurations.
    cur_req = "R2";
    a_v = 1'b1; a_a = 64'd3; a_b = 64'd5;
    s_v = 1'b1; s_a = 8'd7; s_b = 8'd9;
    step();
    a_v = 1'b0; s_v = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      #1;
      chk(a_ov == (k == BLAT), "R2", 128'(a_ov), 128'(k == BLAT));
      chk(s_ov == (k == SLAT), "R2", 128'(s_ov), 128'(k == SLAT));
      step();
    end

    // R1: corner pairs back to back, including all-ones squared.
    cur_req = "R1";
    lat_mode = 1'b1;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        a_v = 1'b1; a_a = corners[i]; a_b = corners[j]; step();
      end
    drain();
    a_v = 1'b1; a_a = '1; a_b = '1; step();
    a_v = 1'b0;
    for (int k = 1; k < BLAT; k++) step();
    #1; chk(a_ov && a_p == 128'hFFFF_FFFF_FFFF_FFFE_0000_0000_0000_0001, "R1",
            a_p, 128'hFFFF_FFFF_FFFF_FFFE_0000_0000_0000_0001);
    drain();

    // R3: random pairs every clock, each exactly BLAT cycles later.
    cur_req = "R3";
    for (int k = 0; k < 1000; k++) begin
      a_v = 1'b1; a_a = {$urandom, $urandom}; a_b = {$urandom, $urandom}; step();
    end
    drain();

    // R4: random bubbles on the input.
    cur_req = "R4";
    for (int k = 0; k < 300; k++) begin
      a_v = $urandom_range(0, 1); a_a = {$urandom, $urandom}; a_b = {$urandom, $urandom}; step();
    end
    drain();
    #1; chk(qb.size() == 0 && !a_ov, "R4", 128'(qb.size()), 128'd0);

    // R6: random back-pressure with offered inputs during stalls.
    cur_req = "R6";
    lat_mode = 1'b0;
    for (int k = 0; k < 400; k++) begin
      a_v = $urandom_range(0, 1); a_r = ($urandom_range(0, 9) < 6);
      a_a = {$urandom, $urandom}; a_b = {$urandom, $urandom}; step();
    end
    drain();
    #1; chk(qb.size() == 0, "R6", 128'(qb.size()), 128'd0);

    // R5: reset with products in flight.
    for (int k = 0; k < 3; k++) begin
      a_v = 1'b1; s_v = 1'b1; a_a = {$urandom, $urandom}; a_b = 64'd11; step();
    end
    a_v = 1'b0; s_v = 1'b0; rst = 1'b1; step();
    rst = 1'b0; qb.delete(); qbt.delete(); qs.delete(); qst.delete();
    for (int k = 0; k < 12; k++) begin
      #1; chk(!a_ov && !s_ov, "R5", 128'(a_ov), 128'd0);
      step();
    end

    // R7: exhaustive sweep of the small two-level configuration.
    cur_req = "R1";
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++) begin
        s_v = 1'b1; s_a = 8'(i); s_b = 8'(j); step();
      end
    drain();
    #1; chk(qs.size() == 0 && !s_ov, "R7", 128'(qs.size()), 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule